// File: doc/BRIEF.md
# Receive Frame Buffer with Overrun Recovery

This block sits between a receive path that has already removed packet headers and checked the frame CRC, and an application that consumes the payload at its own pace. The upstream side offers one 64-bit payload word per cycle with a last-word marker. With the last word it also gives the frame's source IPv4 address, its source UDP port and a CRC-error flag. The block never back-pressures that side. It stores the words in a ring buffer and queues the per-frame metadata in a second ring. The application reads the words one at a time through an acknowledge handshake.

Errors are reported in-band. The end-of-frame word carries a bad-frame flag and an overrun flag. When the buffer runs out of room inside a frame, the rest of that frame is thrown away. The words already stored are closed by an all-zero terminator word that carries end-of-frame and overrun. The write side then stays blocked, and drops every incoming word, until it sees the overrun acknowledge. Wiring the overrun output straight back to the overrun acknowledge gives hands-free recovery.

Top module: `rx_frame_buf`

## Requirements
- R1: During and right after reset, out_valid, out_eof, out_bad and out_ovr are all 0.
- R2: out_valid is 1 exactly while the buffer holds at least one word. Words come out in the order they arrived.
- R3: A word stays on out_data until out_ack is high on a clock edge while out_valid is 1; the next word is then presented. out_ack while out_valid is 0 has no effect.
- R4: out_eof is 1 together with the last word of every frame, and 0 on all other words.
- R5: out_bad is 1 only on an end-of-frame word, and only when the CRC-error flag was 1 alongside that frame's last input word.
- R6: On the end-of-frame word, out_src_ip and out_src_port carry the values that were given with that frame's last input word.
- R7: Suppose a word arrives while the buffer already holds DEPTH-1 words and no overrun is pending. That word and the rest of its frame are discarded. One terminator word is appended with data 0, out_eof=1, out_ovr=1, out_bad=0 and zero source fields.
- R8: After an overrun, all input words are dropped until the overrun acknowledge has been seen and the discarded frame's last word has gone by.
- R9: With ovr_ack tied to out_ovr, the first frame that arrives after the terminator has been read is accepted normally.
- R10: ovr_ack while no overrun is pending has no effect on later frames.
- R11: No fixed frame length applies. A frame of DEPTH-1 words arriving into an empty buffer is stored whole, with out_ovr 0 on its last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Upstream word present this cycle |
| in_data | input | 64 | Upstream payload word |
| in_last | input | 1 | Marks the last word of a frame |
| in_src_ip | input | 32 | Source IPv4 address, sampled with in_last |
| in_src_port | input | 16 | Source UDP port, sampled with in_last |
| in_crc_err | input | 1 | CRC error for the frame, sampled with in_last |
| out_valid | output | 1 | A stored word is on out_data |
| out_data | output | 64 | Current payload word |
| out_eof | output | 1 | Current word ends a frame |
| out_bad | output | 1 | CRC error on the frame ending here |
| out_ovr | output | 1 | The frame ending here was cut by an overrun |
| out_src_ip | output | 32 | Source IPv4 address of the head frame |
| out_src_port | output | 16 | Source UDP port of the head frame |
| out_ack | input | 1 | Consume the current word |
| ovr_ack | input | 1 | Release the blocked write side after an overrun |

## Verification
The hardest state to reach is the blocked write side with an empty buffer and no acknowledge yet given. In that state a correct design must still swallow whole frames. The bench gets there by untying ovr_ack, overfilling the buffer with a frame longer than DEPTH, and draining everything including the terminator. It then sends a frame that must not appear, and only after a manual acknowledge pulse sends one that must. The automatic recovery path is covered by the same overfill with ovr_ack tied to out_ovr.

// File: rtl/rxb_pkg.sv
// Shared types for the receive frame buffer.
// Assumes IPv4 addresses and UDP port numbers keep their protocol widths.
package rxb_pkg;
    localparam int IP_W   = 32;
    localparam int PORT_W = 16;

    // Per-frame record kept in the metadata ring
    typedef struct packed {
        logic [IP_W-1:0]   ip;
        logic [PORT_W-1:0] port;
        logic              bad;
        logic              ovr;
    } rxb_meta_t;

    localparam int META_W = $bits(rxb_meta_t);

    typedef enum logic {
        WR_PASS = 1'b0,
        WR_HOLD = 1'b1
    } rxb_wr_state_e;
endpackage

// File: rtl/rxb_ring.sv
// Generic ring buffer with a combinational head read and an occupancy count.
// Assumes the caller never pushes when full and never pops when empty.
// Push and pop may happen in the same cycle.
module rxb_ring #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;

    // Advance a pointer with wrap at DEPTH
    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write
    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wdata;
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= nxt(wptr);
            if (pop)  rptr <= nxt(rptr);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign rdata = mem[rptr];

    a_r2_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));
    a_r7_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (count != CW'(DEPTH)));
endmodule

// File: rtl/rxb_wr_ctrl.sv
// Write-side controller. It stores incoming words while a spare slot stays
// reserved. The first word that would eat into that slot becomes an overrun
// terminator; after it the controller drops input until released.
// Assumes the data ring count is registered and counts pops conservatively.
module rxb_wr_ctrl
    import rxb_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic [IP_W-1:0]   in_src_ip,
    input  logic [PORT_W-1:0] in_src_port,
    input  logic              in_crc_err,
    input  logic              ovr_ack,
    input  logic [CW-1:0]     dcount,
    output logic              dpush,
    output logic [DATA_W:0]   dwdata,
    output logic              mpush,
    output logic [META_W-1:0] mwdata
);
    rxb_wr_state_e state, state_n;
    logic          mid, mid_n;     // discarded frame still arriving
    logic          got, got_n;     // overrun acknowledge seen while held
    rxb_meta_t     meta;

    // Next-state and write decisions
    always_comb begin
        state_n = state;
        mid_n   = mid;
        got_n   = got;
        dpush   = 1'b0;
        dwdata  = '0;
        mpush   = 1'b0;
        meta    = '0;
        case (state)
            WR_PASS: begin
                if (in_valid) begin
                    dpush = 1'b1;
                    if (dcount < CW'(DEPTH - 1)) begin
                        dwdata = {in_last, in_data};
                        if (in_last) begin
                            mpush     = 1'b1;
                            meta.ip   = in_src_ip;
                            meta.port = in_src_port;
                            meta.bad  = in_crc_err;
                        end
                    end else begin
                        dwdata   = {1'b1, {DATA_W{1'b0}}};
                        mpush    = 1'b1;
                        meta.ovr = 1'b1;
                        state_n  = WR_HOLD;
                        mid_n    = !in_last;
                        got_n    = 1'b0;
                    end
                end
            end
            default: begin
                if (in_valid && in_last) mid_n = 1'b0;
                if (ovr_ack) got_n = 1'b1;
                if ((got || ovr_ack) && !mid && (dcount != CW'(DEPTH))) begin
                    state_n = WR_PASS;
                    got_n   = 1'b0;
                end
            end
        endcase
    end

    assign mwdata = meta;

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WR_PASS;
            mid   <= 1'b0;
            got   <= 1'b0;
        end else begin
            state <= state_n;
            mid   <= mid_n;
            got   <= got_n;
        end
    end

    a_r7_slot_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WR_PASS) |-> (dcount <= CW'(DEPTH - 1)));
    a_r8_hold_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WR_HOLD) |-> !dpush && !mpush);
    a_r8_release_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == WR_HOLD) && !got && !ovr_ack) |=> (state == WR_HOLD));
endmodule

// File: rtl/rx_frame_buf.sv
// Receive frame buffer top. Payload words and their end marker go to the
// data ring. One metadata record per frame goes to a ring of equal depth,
// which therefore never overflows. The metadata head is popped when the
// application acknowledges an end-of-frame word.
// Assumes upstream metadata is valid in the cycle of the frame's last word.
module rx_frame_buf
    import rxb_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic [31:0]       in_src_ip,
    input  logic [15:0]       in_src_port,
    input  logic              in_crc_err,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_eof,
    output logic              out_bad,
    output logic              out_ovr,
    output logic [31:0]       out_src_ip,
    output logic [15:0]       out_src_port,
    input  logic              out_ack,
    input  logic              ovr_ack
);
    logic              dpush, mpush, dpop, mpop;
    logic [DATA_W:0]   dwdata, dhead;
    logic [META_W-1:0] mwdata, mhead_raw;
    logic [CW-1:0]     dcount, mcount;
    rxb_meta_t         mhead;

    rxb_wr_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_wr (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_src_ip(in_src_ip), .in_src_port(in_src_port), .in_crc_err(in_crc_err),
        .ovr_ack(ovr_ack), .dcount(dcount),
        .dpush(dpush), .dwdata(dwdata), .mpush(mpush), .mwdata(mwdata)
    );

    rxb_ring #(.W(DATA_W + 1), .DEPTH(DEPTH)) u_data (
        .clk(clk), .rst_n(rst_n), .push(dpush), .wdata(dwdata),
        .pop(dpop), .rdata(dhead), .count(dcount)
    );

    rxb_ring #(.W(META_W), .DEPTH(DEPTH)) u_meta (
        .clk(clk), .rst_n(rst_n), .push(mpush), .wdata(mwdata),
        .pop(mpop), .rdata(mhead_raw), .count(mcount)
    );

    // Read-side presentation and pop strobes
    always_comb begin
        mhead        = mhead_raw;
        out_valid    = (dcount != '0);
        out_data     = dhead[DATA_W-1:0];
        out_eof      = out_valid && dhead[DATA_W];
        out_bad      = out_eof && mhead.bad;
        out_ovr      = out_eof && mhead.ovr;
        out_src_ip   = mhead.ip;
        out_src_port = mhead.port;
        dpop         = out_ack && out_valid;
        mpop         = dpop && dhead[DATA_W];
    end

    a_r3_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ack) |=> out_valid && $stable(out_data) && $stable(out_eof));
    a_r6_meta_present: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> (mcount != '0));
    a_r4_meta_not_ahead: assert property (@(posedge clk) disable iff (!rst_n)
        mcount <= dcount);
endmodule

// File: tb/sim_rx_frame_buf.sv
module sim_rx_frame_buf;
    localparam int D = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_last = 1'b0, in_crc_err = 1'b0;
    logic [63:0] in_data = '0;
    logic [31:0] in_src_ip = '0;
    logic [15:0] in_src_port = '0;
    logic        out_valid, out_eof, out_bad, out_ovr;
    logic [63:0] out_data;
    logic [31:0] out_src_ip;
    logic [15:0] out_src_port;
    logic        out_ack = 1'b0;
    logic        tie_mode = 1'b1, man_ack = 1'b0;
    logic        ovr_ack;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    assign ovr_ack = tie_mode ? out_ovr : man_ack;

    always #2 clk = ~clk;

    rx_frame_buf #(.DATA_W(64), .DEPTH(D)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_src_ip(in_src_ip), .in_src_port(in_src_port),
        .in_crc_err(in_crc_err), .out_valid(out_valid), .out_data(out_data),
        .out_eof(out_eof), .out_bad(out_bad), .out_ovr(out_ovr),
        .out_src_ip(out_src_ip), .out_src_port(out_src_port),
        .out_ack(out_ack), .ovr_ack(ovr_ack)
    );

    // Frame table: {len[7:0], ip[31:0], port[15:0], crc, pad[6:0]}
    localparam logic [63:0] FRAMES [5] = '{
        {8'd1, 32'hC0A80101, 16'hC001, 1'b0, 7'd0},
        {8'd3, 32'h0A000002, 16'hD00D, 1'b1, 7'd0},
        {8'd2, 32'hAC100A0B, 16'hFFFF, 1'b0, 7'd0},
        {8'd5, 32'h7F000001, 16'hC350, 1'b1, 7'd0},
        {8'd4, 32'h01020304, 16'h0400, 1'b0, 7'd0}
    };

    function automatic logic [63:0] mkword(input int base, input int i);
        logic [31:0] lo;
        lo = 32'hA5000000 | (32'(base) << 8) | 32'(i);
        return {~lo, lo};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_frame(input int len, input int base, input logic [31:0] ip,
                              input logic [15:0] port, input logic crc);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid    = 1'b1;
            in_data     = mkword(base, i);
            in_last     = (i == len - 1);
            in_src_ip   = ip;
            in_src_port = port;
            in_crc_err  = crc;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic read_word(input string req, input logic [63:0] d, input logic eof,
                             input logic bad, input logic ovr,
                             input logic [31:0] ip, input logic [15:0] port);
        @(negedge clk);
        check({req, " valid"}, 64'(out_valid), 64'd1);
        check({req, " data"}, out_data, d);
        check({req, " eof"}, 64'(out_eof), 64'(eof));
        check({req, " bad"}, 64'(out_bad), 64'(bad));
        check({req, " ovr"}, 64'(out_ovr), 64'(ovr));
        if (eof) begin
            check({req, " ip"}, 64'(out_src_ip), 64'(ip));
            check({req, " port"}, 64'(out_src_port), 64'(port));
        end
        out_ack = 1'b1;
        @(negedge clk);
        out_ack = 1'b0;
    endtask

    task automatic read_frame(input string req, input int len, input int base,
                              input logic [31:0] ip, input logic [15:0] port, input logic crc);
        for (int i = 0; i < len; i++)
            read_word(req, mkword(base, i), i == len - 1, crc && (i == len - 1), 1'b0, ip, port);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=complete");
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 valid", 64'(out_valid), 64'd0);
        check("R1 eof/bad/ovr", {61'd0, out_eof, out_bad, out_ovr}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after release", 64'(out_valid), 64'd0);

        // Table walk: R2 order, R4 eof, R5 bad, R6 source fields
        for (int f = 0; f < 5; f++) begin
            int len;
            len = int'(FRAMES[f][63:56]);
            send_frame(len, f, FRAMES[f][55:24], FRAMES[f][23:8], FRAMES[f][7]);
            if (f == 1) begin
                repeat (3) @(negedge clk);
                check("R3 held without ack", out_data, mkword(f, 0));
            end
            read_frame("R2 R4 R5 R6 table", len, f, FRAMES[f][55:24], FRAMES[f][23:8], FRAMES[f][7]);
            check("R2 empty after frame", 64'(out_valid), 64'd0);
        end

        // R2: two frames queued back to back keep order and metadata
        send_frame(2, 20, 32'h11111111, 16'h1111, 1'b1);
        send_frame(3, 21, 32'h22222222, 16'h2222, 1'b0);
        read_frame("R2 R6 queued first", 2, 20, 32'h11111111, 16'h1111, 1'b1);
        read_frame("R2 R6 queued second", 3, 21, 32'h22222222, 16'h2222, 1'b0);

        // R3: ack on an empty buffer has no effect
        @(negedge clk);
        out_ack = 1'b1;
        repeat (2) @(negedge clk);
        out_ack = 1'b0;
        check("R3 ack on empty", 64'(out_valid), 64'd0);
        send_frame(2, 30, 32'h33333333, 16'h3333, 1'b0);
        read_frame("R3 after empty ack", 2, 30, 32'h33333333, 16'h3333, 1'b0);

        // R11: frame of DEPTH-1 words stored whole
        send_frame(D - 1, 40, 32'h44444444, 16'h4444, 1'b0);
        read_frame("R11 long frame", D - 1, 40, 32'h44444444, 16'h4444, 1'b0);

        // R7 R8 R9: overrun with ovr_ack tied to out_ovr
        send_frame(D + 4, 50, 32'h55555555, 16'h5555, 1'b1);
        send_frame(3, 51, 32'h66666666, 16'h6666, 1'b0);
        for (int i = 0; i < D - 1; i++)
            read_word("R7 kept words", mkword(50, i), 1'b0, 1'b0, 1'b0, 32'h0, 16'h0);
        read_word("R7 terminator", 64'd0, 1'b1, 1'b0, 1'b1, 32'h0, 16'h0);
        @(negedge clk);
        check("R8 frame dropped while held", 64'(out_valid), 64'd0);
        send_frame(2, 52, 32'h77777777, 16'h7777, 1'b1);
        read_frame("R9 auto recovery", 2, 52, 32'h77777777, 16'h7777, 1'b1);

        // R10: stray ovr_ack while nothing is pending
        tie_mode = 1'b0;
        @(negedge clk);
        man_ack = 1'b1;
        repeat (2) @(negedge clk);
        man_ack = 1'b0;
        send_frame(3, 60, 32'h88888888, 16'h8888, 1'b0);
        read_frame("R10 stray ack", 3, 60, 32'h88888888, 16'h8888, 1'b0);

        // R8: manual ack withheld, buffer drained, frames still dropped
        send_frame(D + 1, 70, 32'h99999999, 16'h9999, 1'b0);
        for (int i = 0; i < D - 1; i++)
            read_word("R8 kept words", mkword(70, i), 1'b0, 1'b0, 1'b0, 32'h0, 16'h0);
        read_word("R8 terminator", 64'd0, 1'b1, 1'b0, 1'b1, 32'h0, 16'h0);
        send_frame(2, 71, 32'hAAAAAAAA, 16'hAAAA, 1'b0);
        repeat (2) @(negedge clk);
        check("R8 dropped without ack", 64'(out_valid), 64'd0);
        man_ack = 1'b1;
        @(negedge clk);
        man_ack = 1'b0;
        send_frame(2, 72, 32'hBBBBBBBB, 16'hBBBB, 1'b1);
        read_frame("R8 after manual ack", 2, 72, 32'hBBBBBBBB, 16'hBBBB, 1'b1);
        @(negedge clk);
        check("R2 empty at end", 64'(out_valid), 64'd0);

        done = 1'b1;
        finish_run();
    end
endmodule